// File: doc/BRIEF.md
# Dual-Copy Condition and Status Register

This block holds the condition-code and status word of a small processor that keeps one copy for supervisor mode and one for user mode. Each copy is 32 bits wide. The low four bits carry the ALU flags, and the next three bits are the sleep, interrupt-enable and single-step controls. Above those sit bits that record why the processor left user mode: a break, a soft trap, a bus error, a division by zero or a floating-point fault. Only in the supervisor copy, bit 7 instead enables the break-to-debugger behaviour.

The block also decides what an event does. A fault raised in user mode sets its flag in the user copy and asks the core to switch to supervisor mode. The same fault raised in supervisor mode sets the flag in the supervisor copy and halts the core for an external debugger. A return-to-user pulse wipes every reason bit in the user copy. Writes reach the register in three ways:
- the CPU running in supervisor mode, which may write either copy;
- the CPU running in user mode, which always writes its own copy and cannot touch the reason bits;
- an external debugger, which may write either copy.

A supervisor write that sets bit 14 produces a one-cycle instruction-cache clear pulse.

Top module: `mode_flag_reg`

## Requirements
- R1: When `alu_we_i` is high, bits [3:0] of the copy that belongs to the current mode (zero at bit 0, carry at 1, negative at 2, overflow at 3) take `alu_flags_i`, visible after the next clock edge. A write to the same copy in the same cycle takes precedence over the ALU update.
- R2: Bits 4 (sleep), 5 (interrupt enable) and 6 (single step) are plain read/write in both copies. `idle_o` is high while bits 4 and 5 are both set in the supervisor copy.
- R3: A CPU write in user mode always lands in the user copy, whatever `cpu_wr_usr_i` says, and changes only bits [6:0]. Supervisor copy bit 7 (break enable) is written only by a supervisor-mode CPU write or by a debugger write.
- R4: A break in user mode pulses `halt_o` high if supervisor bit 7 is set. If that bit is clear, the break instead pulses `to_sup_o` for one cycle and sets user copy bit 7.
- R5: A break in supervisor mode sets `halt_o` regardless of supervisor bit 7.
- R6: A trap request in user mode sets user copy bit 9 and pulses `to_sup_o`. A trap request in supervisor mode has no effect on either copy or on any output.
- R7: In user mode, bus error, divide-by-zero and floating-point fault set user copy bits 10, 11 and 12 respectively, and pulse `to_sup_o` for one cycle.
- R8: In supervisor mode, the same faults set supervisor copy bits 10, 11 and 12 and set `halt_o`.
- R9: `to_user_i` clears user copy bits 7, 9, 10, 11 and 12, and leaves the supervisor copy unchanged. An event in the same cycle still sets its bit.
- R10: A supervisor-mode CPU write or a debugger write can only clear the reason bits: user bits 7 and 9 to 12, and supervisor bits 10 to 12. Each such bit becomes old AND written value. A user-mode write leaves these bits unchanged.
- R11: A supervisor-mode CPU write to the supervisor copy with data bit 14 set makes `cache_clr_o` high for exactly the following cycle. A debugger write with bit 14 set does not. Bit 14 always reads 0.
- R12: Bits 8, 13 and 15 to 31 read 0 in both copies whatever is written.
- R13: Reset clears both copies and all outputs. After that, `halt_o` stays high until a debugger write to the supervisor copy is made in a cycle without a new halt event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sup_i | input | 1 | Current mode, 1 = supervisor; tags every event and CPU write |
| alu_we_i | input | 1 | ALU flag update strobe |
| alu_flags_i | input | FLAG_W | New ALU flags {V,N,C,Z} |
| brk_i | input | 1 | Break executed this cycle |
| trap_i | input | 1 | Soft trap requested this cycle |
| bus_err_i | input | 1 | Bus error this cycle |
| div_zero_i | input | 1 | Division by zero this cycle |
| fpu_err_i | input | 1 | Floating-point fault this cycle |
| to_user_i | input | 1 | Return-to-user pulse |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wr_usr_i | input | 1 | CPU write target: 1 = user copy (honoured in supervisor mode only) |
| cpu_wr_data_i | input | CC_W | CPU write data |
| dbg_wr_i | input | 1 | Debugger write strobe |
| dbg_wr_usr_i | input | 1 | Debugger write target: 1 = user copy |
| dbg_wr_data_i | input | CC_W | Debugger write data |
| sup_cc_o | output | CC_W | Supervisor copy |
| usr_cc_o | output | CC_W | User copy |
| halt_o | output | 1 | Sticky halt request for the debugger |
| to_sup_o | output | 1 | One-cycle switch-to-supervisor request |
| cache_clr_o | output | 1 | One-cycle instruction-cache clear pulse |
| idle_o | output | 1 | Wait-for-interrupt (supervisor sleep and enable both set) |

## Verification
The bench builds the block with its defaults, CC_W = 32 and FLAG_W = 4. At that size, all sixteen ALU flag patterns can be swept in each mode. So can all 64 combinations of mode, break, trap and the three faults, each starting from a cleared register. A single-bit write walk across all 32 positions, for both copies and both privileged writers, reaches every reserved bit. A long stream of pseudo-random vectors then mixes writes, returns to user mode and events in the same cycle, so that the priority rules between them are exercised.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  localparam int unsigned B_SLEEP = 4;
  localparam int unsigned B_GIE   = 5;
  localparam int unsigned B_STEP  = 6;
  localparam int unsigned B_BRK   = 7;
  localparam int unsigned B_TRAP  = 9;
  localparam int unsigned B_BUS   = 10;
  localparam int unsigned B_DIV   = 11;
  localparam int unsigned B_FPE   = 12;
  localparam int unsigned B_CCLR  = 14;
  localparam int unsigned MIN_W   = 15;
endpackage

// File: rtl/mfr_copy.sv
module mfr_copy
  import mfr_pkg::*;
#(
  parameter int unsigned CC_W   = 32,
  parameter int unsigned FLAG_W = 4,
  parameter bit          IS_SUP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_priv_i,
  input  logic [CC_W-1:0]   wr_data_i,
  input  logic              alu_we_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  input  logic              auto_clr_i,
  input  logic [CC_W-1:0]   set_i,
  output logic [CC_W-1:0]   q_o
);
  localparam logic [CC_W-1:0] ONE    = CC_W'(1);
  localparam logic [CC_W-1:0] PLAIN  = (ONE << (B_BRK)) - ONE;
  localparam logic [CC_W-1:0] BRKM   = ONE << B_BRK;
  localparam logic [CC_W-1:0] EXCM   = (ONE << B_TRAP) | (ONE << B_BUS) |
                                       (ONE << B_DIV) | (ONE << B_FPE);
  // supervisor: bit 7 is a control; user: bit 7 is a sticky reason flag
  localparam logic [CC_W-1:0] STICKY = IS_SUP ? EXCM : (EXCM | BRKM);
  localparam logic [CC_W-1:0] PRIVRW = IS_SUP ? (PLAIN | BRKM) : PLAIN;

  logic [CC_W-1:0] q_q, nxt;

  always_comb begin
    nxt = q_q;
    if (wr_i) begin
      if (wr_priv_i)
        nxt = (wr_data_i & PRIVRW) | (q_q & wr_data_i & STICKY);
      else
        nxt = (q_q & STICKY) | (wr_data_i & PLAIN);
    end else if (alu_we_i) begin
      nxt[FLAG_W-1:0] = alu_flags_i;
    end
    if (auto_clr_i) nxt = nxt & ~STICKY;
    nxt = nxt | (set_i & STICKY);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt;

  assign q_o = q_q;

  a_r12_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q & ~(PRIVRW | STICKY)) == '0);

  a_r9_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_clr_i && ((set_i & STICKY) == '0)) |=> ((q_q & STICKY) == '0));

  a_r10_user_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_priv_i && !auto_clr_i && ((set_i & STICKY) == '0))
      |=> ((q_q & STICKY) == ($past(q_q) & STICKY)));
endmodule

// File: rtl/mfr_evt.sv
module mfr_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_sup_i,
  input  logic brk_i,
  input  logic trap_i,
  input  logic bus_i,
  input  logic div_i,
  input  logic fpe_i,
  input  logic brk_en_i,
  input  logic cache_req_i,
  input  logic halt_rel_i,
  output logic usr_brk_o,
  output logic halt_o,
  output logic to_sup_o,
  output logic cache_clr_o
);
  logic fault, halt_evt, sup_evt;
  logic halt_q, to_sup_q, cclr_q;

  assign fault     = bus_i | div_i | fpe_i;
  assign usr_brk_o = !mode_sup_i && brk_i && !brk_en_i;
  assign halt_evt  = mode_sup_i ? (brk_i | fault) : (brk_i & brk_en_i);
  assign sup_evt   = !mode_sup_i && (trap_i | fault | (brk_i & !brk_en_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      halt_q   <= 1'b0;
      to_sup_q <= 1'b0;
      cclr_q   <= 1'b0;
    end else begin
      if (halt_evt)        halt_q <= 1'b1;
      else if (halt_rel_i) halt_q <= 1'b0;
      to_sup_q <= sup_evt;
      cclr_q   <= cache_req_i;
    end

  assign halt_o      = halt_q;
  assign to_sup_o    = to_sup_q;
  assign cache_clr_o = cclr_q;

  a_r5_sup_break_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sup_i && brk_i) |=> halt_o);

  a_r8_sup_fault_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sup_i && fault) |=> (halt_o && !to_sup_o));

  a_r7_user_fault_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_sup_i && (fault || trap_i)) |=> to_sup_o);

  a_r11_clear_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_clr_o |-> $past(cache_req_i));

  a_r13_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !halt_rel_i) |=> halt_o);
endmodule

// File: rtl/mode_flag_reg.sv
module mode_flag_reg
  import mfr_pkg::*;
#(
  parameter int unsigned CC_W   = 32,
  parameter int unsigned FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sup_i,
  input  logic              alu_we_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  input  logic              brk_i,
  input  logic              trap_i,
  input  logic              bus_err_i,
  input  logic              div_zero_i,
  input  logic              fpu_err_i,
  input  logic              to_user_i,
  input  logic              cpu_wr_i,
  input  logic              cpu_wr_usr_i,
  input  logic [CC_W-1:0]   cpu_wr_data_i,
  input  logic              dbg_wr_i,
  input  logic              dbg_wr_usr_i,
  input  logic [CC_W-1:0]   dbg_wr_data_i,
  output logic [CC_W-1:0]   sup_cc_o,
  output logic [CC_W-1:0]   usr_cc_o,
  output logic              halt_o,
  output logic              to_sup_o,
  output logic              cache_clr_o,
  output logic              idle_o
);
  logic            dbg_s, dbg_u, cpu_s, cpu_u, cpu_own;
  logic            s_wr, u_wr, u_priv, usr_brk;
  logic [CC_W-1:0] s_dat, u_dat, s_set, u_set;

  assign dbg_s   = dbg_wr_i && !dbg_wr_usr_i;
  assign dbg_u   = dbg_wr_i &&  dbg_wr_usr_i;
  assign cpu_s   = cpu_wr_i &&  mode_sup_i && !cpu_wr_usr_i;
  assign cpu_u   = cpu_wr_i &&  mode_sup_i &&  cpu_wr_usr_i;
  assign cpu_own = cpu_wr_i && !mode_sup_i;

  // debugger data wins a same-cycle collision
  assign s_wr   = dbg_s | cpu_s;
  assign s_dat  = dbg_s ? dbg_wr_data_i : cpu_wr_data_i;
  assign u_priv = dbg_u | cpu_u;
  assign u_wr   = u_priv | cpu_own;
  assign u_dat  = dbg_u ? dbg_wr_data_i : cpu_wr_data_i;

  always_comb begin
    s_set = '0;
    u_set = '0;
    if (mode_sup_i) begin
      s_set[B_BUS] = bus_err_i;
      s_set[B_DIV] = div_zero_i;
      s_set[B_FPE] = fpu_err_i;
    end else begin
      u_set[B_BRK]  = usr_brk;
      u_set[B_TRAP] = trap_i;
      u_set[B_BUS]  = bus_err_i;
      u_set[B_DIV]  = div_zero_i;
      u_set[B_FPE]  = fpu_err_i;
    end
  end

  mfr_copy #(.CC_W(CC_W), .FLAG_W(FLAG_W), .IS_SUP(1'b1)) u_sup (
    .clk_i, .rst_ni,
    .wr_i(s_wr), .wr_priv_i(1'b1), .wr_data_i(s_dat),
    .alu_we_i(alu_we_i && mode_sup_i), .alu_flags_i,
    .auto_clr_i(1'b0), .set_i(s_set), .q_o(sup_cc_o)
  );

  mfr_copy #(.CC_W(CC_W), .FLAG_W(FLAG_W), .IS_SUP(1'b0)) u_usr (
    .clk_i, .rst_ni,
    .wr_i(u_wr), .wr_priv_i(u_priv), .wr_data_i(u_dat),
    .alu_we_i(alu_we_i && !mode_sup_i), .alu_flags_i,
    .auto_clr_i(to_user_i), .set_i(u_set), .q_o(usr_cc_o)
  );

  mfr_evt u_evt (
    .clk_i, .rst_ni,
    .mode_sup_i,
    .brk_i, .trap_i,
    .bus_i(bus_err_i), .div_i(div_zero_i), .fpe_i(fpu_err_i),
    .brk_en_i(sup_cc_o[B_BRK]),
    .cache_req_i(cpu_s && cpu_wr_data_i[B_CCLR]),
    .halt_rel_i(dbg_s),
    .usr_brk_o(usr_brk),
    .halt_o, .to_sup_o, .cache_clr_o
  );

  assign idle_o = sup_cc_o[B_SLEEP] & sup_cc_o[B_GIE];

  a_r6_sup_trap_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sup_i && trap_i && !brk_i && !bus_err_i && !div_zero_i && !fpu_err_i)
      |=> !to_sup_o);

  a_r3_user_write_spares_sup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_sup_i && !dbg_s && !bus_err_i && !div_zero_i && !fpu_err_i && !alu_we_i)
      |=> $stable(sup_cc_o));

  a_r11_bit14_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_cc_o[B_CCLR] && !usr_cc_o[B_CCLR]);
endmodule

// File: tb/tb_mode_flag_reg.sv
module tb_mode_flag_reg;
  localparam int CC_W = 32;
  localparam int FLAG_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m, alu_we, brk, trap, bus, dvz, fpe, to_usr, cwr, csel_u, dwr, dsel_u;
  logic [FLAG_W-1:0] alu_f;
  logic [CC_W-1:0] cdat, ddat;
  logic [CC_W-1:0] sup_cc, usr_cc;
  logic halt, to_sup, cclr, idle;

  mode_flag_reg #(.CC_W(CC_W), .FLAG_W(FLAG_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_sup_i(m),
    .alu_we_i(alu_we), .alu_flags_i(alu_f),
    .brk_i(brk), .trap_i(trap), .bus_err_i(bus), .div_zero_i(dvz), .fpu_err_i(fpe),
    .to_user_i(to_usr),
    .cpu_wr_i(cwr), .cpu_wr_usr_i(csel_u), .cpu_wr_data_i(cdat),
    .dbg_wr_i(dwr), .dbg_wr_usr_i(dsel_u), .dbg_wr_data_i(ddat),
    .sup_cc_o(sup_cc), .usr_cc_o(usr_cc), .halt_o(halt), .to_sup_o(to_sup),
    .cache_clr_o(cclr), .idle_o(idle)
  );

  int vectors = 0;
  int errors = 0;
  logic [CC_W-1:0] e_sup = '0, e_usr = '0;
  logic e_halt = 0, e_tosup = 0, e_cclr = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic quiet();
    m = 0; alu_we = 0; alu_f = '0; brk = 0; trap = 0; bus = 0; dvz = 0; fpe = 0;
    to_usr = 0; cwr = 0; csel_u = 0; cdat = '0; dwr = 0; dsel_u = 0; ddat = '0;
  endtask

  task automatic check(input string tag);
    logic e_idle;
    e_idle = e_sup[4] & e_sup[5];
    vectors++;
    if (sup_cc !== e_sup || usr_cc !== e_usr || halt !== e_halt ||
        to_sup !== e_tosup || cclr !== e_cclr || idle !== e_idle) begin
      errors++;
      $display("FAIL %s: sup=%h usr=%h halt=%b tosup=%b cclr=%b idle=%b | exp sup=%h usr=%h halt=%b tosup=%b cclr=%b idle=%b",
               tag, sup_cc, usr_cc, halt, to_sup, cclr, idle,
               e_sup, e_usr, e_halt, e_tosup, e_cclr, e_idle);
    end
  endtask

  // expected next state, from the requirement list
  task automatic step(input string tag);
    logic sw, up, uo, be, hev;
    logic [CC_W-1:0] sd, ud, ns, nu;
    sw = (dwr && !dsel_u) || (cwr && m && !csel_u);
    sd = (dwr && !dsel_u) ? ddat : cdat;
    up = (dwr && dsel_u) || (cwr && m && csel_u);
    uo = cwr && !m;
    ud = (dwr && dsel_u) ? ddat : cdat;
    be = e_sup[7];
    ns = e_sup;
    if (sw) ns = (sd & 32'h0000_00FF) | (e_sup & sd & 32'h0000_1C00);
    else if (alu_we && m) ns[3:0] = alu_f;
    if (m) begin
      if (bus) ns[10] = 1'b1;
      if (dvz) ns[11] = 1'b1;
      if (fpe) ns[12] = 1'b1;
    end
    nu = e_usr;
    if (up) nu = (ud & 32'h0000_007F) | (e_usr & ud & 32'h0000_1E80);
    else if (uo) nu = (cdat & 32'h0000_007F) | (e_usr & 32'h0000_1E80);
    else if (alu_we && !m) nu[3:0] = alu_f;
    if (to_usr) nu = nu & ~32'h0000_1E80;
    if (!m) begin
      if (brk && !be) nu[7] = 1'b1;
      if (trap) nu[9] = 1'b1;
      if (bus) nu[10] = 1'b1;
      if (dvz) nu[11] = 1'b1;
      if (fpe) nu[12] = 1'b1;
    end
    hev = m ? (brk || bus || dvz || fpe) : (brk && be);
    if (hev) e_halt = 1'b1;
    else if (dwr && !dsel_u) e_halt = 1'b0;
    e_tosup = !m && (trap || bus || dvz || fpe || (brk && !be));
    e_cclr = cwr && m && !csel_u && cdat[14];
    e_sup = ns;
    e_usr = nu;
    @(posedge clk);
    @(negedge clk);
    check(tag);
    quiet();
  endtask

  task automatic wipe();
    dwr = 1; dsel_u = 0; ddat = '0; step("R13");
    dwr = 1; dsel_u = 1; ddat = '0; step("R10");
  endtask

  function automatic logic [31:0] nxt_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, exp done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    check("R13");              // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R13");

    // R1: every flag pattern in each mode, then write beats ALU
    for (int md = 0; md < 2; md++)
      for (int f = 0; f < 16; f++) begin
        m = md[0]; alu_we = 1; alu_f = f[3:0]; step("R1");
      end
    m = 1; alu_we = 1; alu_f = 4'hF; cwr = 1; cdat = 32'h0000_0005; step("R1");

    // R2: controls and idle
    m = 1; cwr = 1; cdat = 32'h0000_0030; step("R2");
    m = 1; cwr = 1; cdat = 32'h0000_0050; step("R2");
    m = 0; cwr = 1; cdat = 32'h0000_0070; step("R2");

    // R3: user write aimed at supervisor copy lands in user copy
    wipe();
    m = 0; cwr = 1; csel_u = 0; cdat = 32'hFFFF_FFFF; step("R3");
    m = 1; cwr = 1; cdat = 32'h0000_0080; step("R3");

    // R4: user break with and without break enable
    m = 0; brk = 1; step("R4");
    dwr = 1; ddat = 32'h0000_0080; step("R13");
    m = 1; cwr = 1; cdat = 32'h0; step("R4");
    m = 0; brk = 1; step("R4");
    step("R4");

    // R5: supervisor break halts with enable clear
    m = 1; brk = 1; step("R5");
    step("R13");
    dwr = 1; ddat = 32'h0; step("R13");

    // R6: trap in each mode
    m = 0; trap = 1; step("R6");
    m = 1; trap = 1; step("R6");

    // R9: return to user clears reasons; R10 clear-only writes
    m = 0; bus = 1; dvz = 1; fpe = 1; step("R7");
    m = 0; cwr = 1; cdat = 32'h0; step("R10");
    m = 1; cwr = 1; csel_u = 1; cdat = 32'hFFFF_F7FF; step("R10");
    m = 1; to_usr = 1; step("R9");
    m = 1; bus = 1; step("R8");
    m = 0; cwr = 1; cdat = 32'h0; step("R10");
    m = 1; cwr = 1; cdat = 32'h0000_1000; step("R10");
    dwr = 1; ddat = 32'h0; step("R10");

    // R11: cache clear pulse
    m = 1; cwr = 1; cdat = 32'h0000_4000; step("R11");
    step("R11");
    dwr = 1; ddat = 32'h0000_4000; step("R11");
    m = 1; cwr = 1; csel_u = 1; cdat = 32'h0000_4000; step("R11");

    // R7/R8/R4/R5/R6: all 64 event combinations from clean state
    for (int c = 0; c < 64; c++) begin
      wipe();
      if (c[5]) begin m = 1; cwr = 1; cdat = 32'h0000_0080; step("R4"); end
      m = c[0]; brk = c[1]; trap = c[2]; bus = c[3]; dvz = c[4]; fpe = c[5];
      step(c[0] ? "R8" : "R7");
      m = c[0]; to_usr = 1; step("R9");
    end

    // R12: single-bit walk through privileged writers into both copies
    for (int b = 0; b < CC_W; b++) begin
      dwr = 1; dsel_u = 0; ddat = CC_W'(1) << b; step("R12");
      dwr = 1; dsel_u = 1; ddat = CC_W'(1) << b; step("R12");
      m = 1; cwr = 1; csel_u = 0; cdat = CC_W'(1) << b; step("R12");
      m = 1; cwr = 1; csel_u = 1; cdat = CC_W'(1) << b; step("R12");
      m = 0; cwr = 1; cdat = CC_W'(1) << b; step("R12");
    end

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, d;
      lfsr = nxt_rand(lfsr); r = lfsr;
      lfsr = nxt_rand(lfsr); d = lfsr;
      m = r[0]; alu_we = r[1]; alu_f = r[5:2];
      brk = &r[8:6]; trap = &r[11:9]; bus = &r[14:12]; dvz = &r[17:15];
      fpe = &r[20:18]; to_usr = &r[22:21];
      cwr = &r[24:23]; csel_u = r[25]; cdat = d;
      dwr = &r[28:26]; dsel_u = r[29]; ddat = {d[15:0], d[31:16]};
      step("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule